// File: doc/BRIEF.md
# Card UART Interrupt Gate

This block collects the interrupt sources of a smart-card UART and drives one host interrupt request. Three kinds of source feed it. A one-cycle character-done pulse marks that the transmit buffer has emptied or the receive buffer has filled. Error pulses come from the UART's own checkers. Either edge on an asynchronous auxiliary input pin also counts as a source. Each source sets a sticky flag, and the interrupt line is a registered OR of the flags that are not masked.

A configuration register holds two disable bits. One blocks character events from the interrupt line. The flag is still set, and a separate poll view shows it, so software can run a fast polling loop. Reading the poll view clears nothing. The other disable bit blocks auxiliary-pin events from the interrupt line, but the auxiliary latch still records them. If software removes that mask while the latch is still set, an interrupt follows, so software should read the auxiliary status before it unmasks. Error flags are never masked.

The host reads the registers through a small select/strobe port with a registered read bus. Reading the UART status word clears the character and error flags. Reading the auxiliary status word clears the auxiliary latch.

Top module: `card_irq_ctrl`

## Requirements
- R1: After synchronous reset the configuration register, every flag and `irq` are 0.
- R2: A write to the configuration register stores bits 6..0. Bit 7 always reads back 0.
- R3: A `char_done` pulse sets the character flag (UART status bit 0) at the next clock edge. With configuration bit 0 clear, `irq` rises one clock after that.
- R4: With configuration bit 0 set, a `char_done` pulse still sets the character flag, and the poll view (select 1, bit 0) reads 1, but `irq` stays 0.
- R5: Reading the poll view clears no flag. A later UART-status read still returns the character flag in bit 0 and pending error flags in bits NERR..1.
- R6: Each rising or falling edge of `aux_pin` sets the auxiliary latch (auxiliary status bit 0) three clocks after the pin changes, through a two-flop synchronizer and an edge stage. Auxiliary status bit 1 shows the synchronized pin level. With configuration bit 1 clear, `irq` rises one clock after the latch sets.
- R7: With configuration bit 1 set, an auxiliary edge still sets the latch but does not raise `irq`.
- R8: Clearing configuration bit 1 while the auxiliary latch is set raises `irq` one clock after the write.
- R9: Reading auxiliary status (select 2) clears the latch. An edge detected in the same cycle as that read wins, and the latch stays set.
- R10: An `err_in` bit pulse sets its sticky flag at the next edge. That flag drives `irq` whatever the mask bits are, and a UART-status read (select 0) clears it.
- R11: `irq` is registered. It falls one clock after the last unmasked flag clears.
- R12: `rd_data` updates one clock after `rd_en`. It shows the selected word as it stood before any clear caused by that read. Select 3 returns the configuration register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | DW | Configuration write data |
| rd_en | input | 1 | Register read strobe |
| rd_sel | input | 2 | Read select: 0 UART status, 1 poll view, 2 aux status, 3 configuration |
| rd_data | output | DW | Registered read data |
| char_done | input | 1 | Character transmitted or received pulse |
| err_in | input | NERR | UART error event pulses |
| aux_pin | input | 1 | Asynchronous auxiliary interrupt pin |
| irq | output | 1 | Active-high interrupt request |

## Verification
Each result has a fixed latency. A flag set by a pulse is visible one edge later. `irq` follows a flag by one more edge, or follows an unmasking write by one edge. The auxiliary latch sets three edges after the pin moves. Read data appears on the edge that takes the read strobe. The bench drives inputs on the falling clock edge and steps whole cycles. It samples `irq` exactly on the cycle where it is due, and it also samples the cycle just before, to confirm that the output is not early. For the collision case the bench times the read so that it meets the edge detection in the same cycle.

// File: rtl/card_irq_pkg.sv
package card_irq_pkg;
  // configuration bit positions that the gate decodes
  localparam int CHAR_OFF_BIT = 0;
  localparam int AUX_OFF_BIT  = 1;

  typedef enum logic [1:0] {
    SEL_UART = 2'd0,
    SEL_POLL = 2'd1,
    SEL_AUX  = 2'd2,
    SEL_CFG  = 2'd3
  } rd_sel_e;
endpackage

// File: rtl/cirq_sync_edge.sv
module cirq_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_i,
  output logic level_o,
  output logic edge_o
);
  logic [STAGES-1:0] sh;
  logic              prev;

  always_ff @(posedge clk) begin
    if (rst) sh[0] <= 1'b0;
    else     sh[0] <= pin_i;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) sh[i] <= 1'b0;
      else     sh[i] <= sh[i-1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) prev <= 1'b0;
    else     prev <= sh[STAGES-1];
  end

  assign level_o = sh[STAGES-1];
  assign edge_o  = sh[STAGES-1] ^ prev;
endmodule

// File: rtl/cirq_flags.sv
module cirq_flags #(
  parameter int NERR = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            char_done_i,
  input  logic [NERR-1:0] err_i,
  input  logic            aux_edge_i,
  input  logic            clr_uart_i,
  input  logic            clr_aux_i,
  output logic            char_flag_o,
  output logic [NERR-1:0] err_flags_o,
  output logic            aux_flag_o
);
  // set always beats clear
  always_ff @(posedge clk) begin
    if (rst)              char_flag_o <= 1'b0;
    else if (char_done_i) char_flag_o <= 1'b1;
    else if (clr_uart_i)  char_flag_o <= 1'b0;
  end

  for (genvar e = 0; e < NERR; e++) begin : g_err
    always_ff @(posedge clk) begin
      if (rst)             err_flags_o[e] <= 1'b0;
      else if (err_i[e])   err_flags_o[e] <= 1'b1;
      else if (clr_uart_i) err_flags_o[e] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)             aux_flag_o <= 1'b0;
    else if (aux_edge_i) aux_flag_o <= 1'b1;
    else if (clr_aux_i)  aux_flag_o <= 1'b0;
  end
endmodule

// File: rtl/cirq_merge.sv
module cirq_merge #(
  parameter int NERR = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            char_flag_i,
  input  logic            aux_flag_i,
  input  logic [NERR-1:0] err_flags_i,
  input  logic            char_off_i,
  input  logic            aux_off_i,
  output logic            irq_o
);
  logic req;

  assign req = (char_flag_i & ~char_off_i)
             | (aux_flag_i  & ~aux_off_i)
             | (|err_flags_i);

  always_ff @(posedge clk) begin
    if (rst) irq_o <= 1'b0;
    else     irq_o <= req;
  end
endmodule

// File: rtl/card_irq_ctrl.sv
module card_irq_ctrl
  import card_irq_pkg::*;
#(
  parameter int DW          = 8,
  parameter int NERR        = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cfg_we,
  input  logic [DW-1:0]   cfg_wdata,
  input  logic            rd_en,
  input  logic [1:0]      rd_sel,
  output logic [DW-1:0]   rd_data,
  input  logic            char_done,
  input  logic [NERR-1:0] err_in,
  input  logic            aux_pin,
  output logic            irq
);
  localparam int UART_USED = NERR + 1;

  logic [DW-1:0]   cfg_q;
  logic            char_flag;
  logic            aux_flag;
  logic [NERR-1:0] err_flags;
  logic            aux_edge;
  logic            aux_level;
  logic            clr_uart;
  logic            clr_aux;
  logic [DW-1:0]   uart_word;
  logic [DW-1:0]   poll_word;
  logic [DW-1:0]   aux_word;

  // top configuration bit is unused and held at 0
  always_ff @(posedge clk) begin
    if (rst)         cfg_q <= '0;
    else if (cfg_we) cfg_q <= {1'b0, cfg_wdata[DW-2:0]};
  end

  assign clr_uart = rd_en && (rd_sel == SEL_UART);
  assign clr_aux  = rd_en && (rd_sel == SEL_AUX);

  cirq_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .pin_i   (aux_pin),
    .level_o (aux_level),
    .edge_o  (aux_edge)
  );

  cirq_flags #(.NERR(NERR)) u_flags (
    .clk         (clk),
    .rst         (rst),
    .char_done_i (char_done),
    .err_i       (err_in),
    .aux_edge_i  (aux_edge),
    .clr_uart_i  (clr_uart),
    .clr_aux_i   (clr_aux),
    .char_flag_o (char_flag),
    .err_flags_o (err_flags),
    .aux_flag_o  (aux_flag)
  );

  cirq_merge #(.NERR(NERR)) u_merge (
    .clk         (clk),
    .rst         (rst),
    .char_flag_i (char_flag),
    .aux_flag_i  (aux_flag),
    .err_flags_i (err_flags),
    .char_off_i  (cfg_q[CHAR_OFF_BIT]),
    .aux_off_i   (cfg_q[AUX_OFF_BIT]),
    .irq_o       (irq)
  );

  always_comb begin
    uart_word                  = '0;
    uart_word[UART_USED-1:0]   = {err_flags, char_flag};
    poll_word                  = '0;
    poll_word[0]               = char_flag;
    aux_word                   = '0;
    aux_word[1:0]              = {aux_level, aux_flag};
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else if (rd_en) begin
      case (rd_sel)
        SEL_UART: rd_data <= uart_word;
        SEL_POLL: rd_data <= poll_word;
        SEL_AUX:  rd_data <= aux_word;
        default:  rd_data <= cfg_q;
      endcase
    end
  end
endmodule

// File: rtl/cirq_checker.sv
module cirq_checker #(
  parameter int DW   = 8,
  parameter int NERR = 3
) (
  input logic            clk,
  input logic            rst,
  input logic            rd_en,
  input logic [1:0]      rd_sel,
  input logic [DW-1:0]   rd_data,
  input logic            char_done,
  input logic [NERR-1:0] err_in,
  input logic            irq,
  input logic            char_flag,
  input logic            aux_flag,
  input logic [NERR-1:0] err_flags,
  input logic            aux_edge
);
  assert_reset_quiet_R1: assert property (@(posedge clk) rst |=> !irq);

  assert_cfg_top_zero_R2: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rd_sel == 2'd3) |=> !rd_data[DW-1]);

  assert_char_sets_flag_R3: assert property (@(posedge clk) disable iff (rst)
    char_done |=> char_flag);

  assert_edge_beats_clear_R9: assert property (@(posedge clk) disable iff (rst)
    (aux_edge && rd_en && rd_sel == 2'd2) |=> aux_flag);

  assert_err_reaches_irq_R10: assert property (@(posedge clk) disable iff (rst)
    (|err_in) |=> ##1 irq);

  assert_idle_drops_irq_R11: assert property (@(posedge clk) disable iff (rst)
    (!char_flag && !aux_flag && err_flags == '0) |=> !irq);
endmodule

bind card_irq_ctrl cirq_checker #(.DW(DW), .NERR(NERR)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .rd_en     (rd_en),
  .rd_sel    (rd_sel),
  .rd_data   (rd_data),
  .char_done (char_done),
  .err_in    (err_in),
  .irq       (irq),
  .char_flag (char_flag),
  .aux_flag  (aux_flag),
  .err_flags (err_flags),
  .aux_edge  (aux_edge)
);

// File: tb/tb_card_irq_ctrl.sv
module tb_card_irq_ctrl;
  localparam int DW   = 8;
  localparam int NERR = 3;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            cfg_we = 1'b0;
  logic [DW-1:0]   cfg_wdata = '0;
  logic            rd_en = 1'b0;
  logic [1:0]      rd_sel = 2'd0;
  logic [DW-1:0]   rd_data;
  logic            char_done = 1'b0;
  logic [NERR-1:0] err_in = '0;
  logic            aux_pin = 1'b0;
  logic            irq;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;  // 50 MHz

  card_irq_ctrl #(.DW(DW), .NERR(NERR), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .rd_en(rd_en), .rd_sel(rd_sel), .rd_data(rd_data),
    .char_done(char_done), .err_in(err_in), .aux_pin(aux_pin), .irq(irq)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic wr_cfg(input logic [DW-1:0] v);
    cfg_we = 1'b1; cfg_wdata = v;
    step();
    cfg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] sel, output int v);
    rd_en = 1'b1; rd_sel = sel;
    step();
    rd_en = 1'b0;
    v = int'(rd_data);
  endtask

  task automatic t_reset();
    int v;
    check("R1 irq", int'(irq), 0);
    rd(2'd3, v); check("R1 cfg", v, 0);
    rd(2'd0, v); check("R1 uart", v, 0);
    rd(2'd2, v); check("R1 aux", v, 0);
  endtask

  task automatic t_cfg();
    int v;
    wr_cfg(8'hFF);
    rd(2'd3, v); check("R2 bit7 zero", v, 'h7F);
    wr_cfg(8'h00);
    rd(2'd3, v); check("R12 cfg readback", v, 0);
  endtask

  task automatic t_char_open();
    int v;
    char_done = 1'b1; step(); char_done = 1'b0;
    check("R3 irq not early", int'(irq), 0);
    step();
    check("R3 irq", int'(irq), 1);
    rd(2'd0, v); check("R12 uart pre-clear", v, 1);
    step();
    check("R11 irq falls", int'(irq), 0);
  endtask

  task automatic t_char_masked();
    int v;
    wr_cfg(8'h01);
    char_done = 1'b1; err_in = 3'b010; step();
    char_done = 1'b0; err_in = '0;
    rd(2'd1, v); check("R4 poll view", v, 1);
    rd(2'd1, v); check("R5 poll again", v, 1);
    rd(2'd0, v); check("R5 uart intact", v, 5);
    rd(2'd1, v); check("R5 poll after uart clear", v, 0);
    // error set, cleared: irq now quiet; char alone must not raise it
    char_done = 1'b1; step(); char_done = 1'b0;
    step(2);
    check("R4 irq masked", int'(irq), 0);
    rd(2'd0, v);
    wr_cfg(8'h00);
  endtask

  task automatic t_aux_open();
    int v;
    aux_pin = 1'b1; step(3);
    check("R6 irq not early", int'(irq), 0);
    step();
    check("R6 irq rise edge", int'(irq), 1);
    rd(2'd2, v); check("R6 aux word", v, 3);
    step();
    check("R9 irq after clear", int'(irq), 0);
    aux_pin = 1'b0; step(3);
    rd(2'd2, v); check("R6 falling edge", v, 1);
  endtask

  task automatic t_aux_masked();
    int v;
    wr_cfg(8'h02);
    aux_pin = 1'b1; step(4);
    check("R7 irq masked", int'(irq), 0);
    wr_cfg(8'h00);
    check("R8 irq not early", int'(irq), 0);
    step();
    check("R8 irq on unmask", int'(irq), 1);
    rd(2'd2, v); check("R7 latch kept", v, 3);
    wr_cfg(8'h02);
    aux_pin = 1'b0; step(4);
    rd(2'd2, v);
    wr_cfg(8'h00);
    step(2);
    check("R9 read before unmask", int'(irq), 0);
  endtask

  task automatic t_collide();
    int v;
    wr_cfg(8'h02);
    aux_pin = 1'b1; step(2);
    rd(2'd2, v); check("R9 pre-value", v, 2);
    rd(2'd2, v); check("R9 edge wins", v, 3);
    rd(2'd2, v); check("R9 cleared", v, 2);
    aux_pin = 1'b0; step(4);
    rd(2'd2, v);
  endtask

  task automatic t_err();
    int v;
    wr_cfg(8'h03);
    err_in = 3'b001; step(); err_in = '0;
    step();
    check("R10 irq unmaskable", int'(irq), 1);
    rd(2'd0, v); check("R10 uart err bit", v, 2);
    step();
    check("R10 irq after clear", int'(irq), 0);
    wr_cfg(8'h00);
  endtask

  initial begin
    step(3);
    rst = 1'b0;
    step();
    t_reset();
    t_cfg();
    t_char_open();
    t_char_masked();
    t_aux_open();
    t_aux_masked();
    t_collide();
    t_err();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule